// File: doc/BRIEF.md
# Timer-Driven Output Compare Unit

This block watches a free-running timer count that lives outside it and drives one output pin from compare events. Software picks a mode code and loads a primary and a secondary compare value through write strobes. The block then changes the pin when the timer count equals one of those values. It has three families of behaviour. Single-match modes force the pin high, force it low or toggle it. Dual-match modes raise the pin on the primary value and drop it on the secondary value, either once or once in every timer period. A PWM mode starts each timer period high and drops the pin at a duty value that is double-buffered.

In PWM mode the duty value in use cannot be written directly. Software writes the secondary compare value, and the block copies it into the active duty register when the timer reports a period match. A duty change written part-way through a cycle therefore takes effect only at the next period boundary, so no short or split pulse can appear. A one-cycle interrupt pulse marks every compare event that moves the pin.

Top module: `ocmp_unit`

## Requirements
- R1: After reset the pin is low, the interrupt output is low and the mode is disabled (code 0).
- R2: With mode code 1, a cycle in which the timer count equals the primary compare value makes the pin high from the next clock on.
- R3: With mode code 2, a cycle in which the timer count equals the primary compare value makes the pin low from the next clock on. Mode code 2 never raises the pin.
- R4: With mode code 3, every cycle in which the timer count equals the primary compare value inverts the pin.
- R5: With mode code 4, the pin rises on the first primary match after the mode write and falls on the next secondary match. Until the mode is written again, it does not rise a second time.
- R6: With mode code 5, the pin rises on a primary match while it is low and falls on a secondary match while it is high. This repeats in every timer period.
- R7: With mode code 6, the period-match strobe copies the secondary compare value into the active duty register and sets the pin high if that value is nonzero. In any other cycle, a count equal to the active duty value sets the pin low. A secondary write does not alter the cycle in progress. With a timer period P and a duty value d with 0 < d < P, the pin is high for d+1 clocks out of every P+1 clocks.
- R8: With mode code 6, a duty value of 0 keeps the pin low for the whole timer period. A duty value greater than the period keeps the pin high for the whole timer period.
- R9: The interrupt output is high for exactly one clock, in the same cycle that the pin takes a new level because of a compare or period event. A mode write never raises it.
- R10: Mode codes 0 and 7 are disabled. Writing either code sets the pin low on the next clock, and while the mode stays disabled the pin stays low and no interrupt occurs.
- R11: In the cycle of a mode write, no compare event acts. A write of an enabled mode code keeps the current pin level. Compare values written in one cycle are used for matching from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmr_cnt_i | input | W | Current count of the external timer |
| tmr_prd_i | input | 1 | Strobe, high in the cycle the timer equals its period |
| mode_i | input | 3 | Mode code to write |
| mode_wr_i | input | 1 | Mode write strobe |
| cmp_a_i | input | W | Primary compare value to write |
| cmp_a_wr_i | input | 1 | Primary compare write strobe |
| cmp_b_i | input | W | Secondary compare value (duty value in PWM mode) |
| cmp_b_wr_i | input | 1 | Secondary compare write strobe |
| pin_o | output | 1 | Output pin level |
| irq_o | output | 1 | One-cycle compare event pulse |

## Verification
Most state errors in this block show at the pin within one timer period. A stale active duty register lengthens or shortens the high time in the very next cycle. A lost arm flag in one-shot mode gives either a missing pulse or a second pulse one period later. The pin level is compared against a behavioural model on every clock, and the high time and edge counts are checked over whole periods. A wrong interrupt shows in the same cycle as the pin change it should mark. A wrong disable path shows one clock after the mode write.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  typedef enum logic [2:0] {
    OC_OFF  = 3'd0,
    OC_SET  = 3'd1,
    OC_CLR  = 3'd2,
    OC_TGL  = 3'd3,
    OC_ONE  = 3'd4,
    OC_RUN  = 3'd5,
    OC_PWM  = 3'd6,
    OC_OFF7 = 3'd7
  } oc_mode_e;

  localparam int unsigned NUM_REFS = 3;
  localparam int unsigned REF_A    = 0;
  localparam int unsigned REF_B    = 1;
  localparam int unsigned REF_DUTY = 2;

  function automatic logic mode_is_off(oc_mode_e m);
    return (m == OC_OFF) || (m == OC_OFF7);
  endfunction
endpackage

// File: rtl/ocmp_regs.sv
module ocmp_regs
  import ocmp_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [2:0]   mode_i,
  input  logic         mode_wr_i,
  input  logic [W-1:0] cmp_a_i,
  input  logic         cmp_a_wr_i,
  input  logic [W-1:0] cmp_b_i,
  input  logic         cmp_b_wr_i,
  input  logic         duty_ld_i,
  output oc_mode_e     mode_o,
  output logic [W-1:0] cmp_a_o,
  output logic [W-1:0] cmp_b_o,
  output logic [W-1:0] duty_o
);
  oc_mode_e     mode_q;
  logic [W-1:0] cmp_a_q, cmp_b_q, duty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= OC_OFF;
      cmp_a_q <= '0;
      cmp_b_q <= '0;
      duty_q  <= '0;
    end else begin
      if (mode_wr_i)  mode_q  <= oc_mode_e'(mode_i);
      if (cmp_a_wr_i) cmp_a_q <= cmp_a_i;
      if (cmp_b_wr_i) cmp_b_q <= cmp_b_i;
      // active duty has no write port: loaded only at period boundary
      if (duty_ld_i)  duty_q  <= cmp_b_q;
    end
  end

  assign mode_o  = mode_q;
  assign cmp_a_o = cmp_a_q;
  assign cmp_b_o = cmp_b_q;
  assign duty_o  = duty_q;
endmodule

// File: rtl/ocmp_match.sv
module ocmp_match
  import ocmp_pkg::*;
#(
  parameter int unsigned W = 16,
  parameter int unsigned N = NUM_REFS
) (
  input  logic [W-1:0]        cnt_i,
  input  logic [N-1:0][W-1:0] ref_i,
  output logic [N-1:0]        hit_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_o[g] = (cnt_i == ref_i[g]);
  end
endmodule

// File: rtl/ocmp_pin.sv
module ocmp_pin
  import ocmp_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  oc_mode_e            mode_q_i,
  input  logic [2:0]          mode_i,
  input  logic                mode_wr_i,
  input  logic                tmr_prd_i,
  input  logic [NUM_REFS-1:0] hit_i,
  input  logic [W-1:0]        next_duty_i,
  output logic                duty_ld_o,
  output logic                pin_o,
  output logic                irq_o,
  output logic                armed_o
);
  logic pin_q, pin_d, armed_q, armed_d, irq_q, irq_d;
  logic rise_ok;

  assign duty_ld_o = !mode_wr_i && (mode_q_i == OC_PWM) && tmr_prd_i;
  assign rise_ok   = armed_q || (mode_q_i == OC_RUN);

  always_comb begin
    pin_d   = pin_q;
    armed_d = armed_q;
    if (mode_wr_i) begin
      if (mode_is_off(oc_mode_e'(mode_i))) pin_d = 1'b0;
      armed_d = (oc_mode_e'(mode_i) == OC_ONE);
    end else begin
      unique case (mode_q_i)
        OC_SET: if (hit_i[REF_A]) pin_d = 1'b1;
        OC_CLR: if (hit_i[REF_A]) pin_d = 1'b0;
        OC_TGL: if (hit_i[REF_A]) pin_d = ~pin_q;
        OC_ONE, OC_RUN: begin
          if (!pin_q && hit_i[REF_A] && rise_ok) begin
            pin_d = 1'b1;
          end else if (pin_q && hit_i[REF_B]) begin
            pin_d = 1'b0;
            if (mode_q_i == OC_ONE) armed_d = 1'b0;
          end
        end
        OC_PWM: begin
          if (tmr_prd_i)           pin_d = (next_duty_i != '0);
          else if (hit_i[REF_DUTY]) pin_d = 1'b0;
        end
        default: pin_d = 1'b0;
      endcase
    end
  end

  assign irq_d = !mode_wr_i && (pin_d != pin_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q   <= 1'b0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      pin_q   <= pin_d;
      armed_q <= armed_d;
      irq_q   <= irq_d;
    end
  end

  assign pin_o   = pin_q;
  assign irq_o   = irq_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit
  import ocmp_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] tmr_cnt_i,
  input  logic         tmr_prd_i,
  input  logic [2:0]   mode_i,
  input  logic         mode_wr_i,
  input  logic [W-1:0] cmp_a_i,
  input  logic         cmp_a_wr_i,
  input  logic [W-1:0] cmp_b_i,
  input  logic         cmp_b_wr_i,
  output logic         pin_o,
  output logic         irq_o
);
  oc_mode_e                   mode_q;
  logic [W-1:0]               cmp_a_q, cmp_b_q, duty_q;
  logic [NUM_REFS-1:0][W-1:0] refs;
  logic [NUM_REFS-1:0]        hits;
  logic                       duty_ld, armed_q;

  ocmp_regs #(.W(W)) regs_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .mode_wr_i  (mode_wr_i),
    .cmp_a_i    (cmp_a_i),
    .cmp_a_wr_i (cmp_a_wr_i),
    .cmp_b_i    (cmp_b_i),
    .cmp_b_wr_i (cmp_b_wr_i),
    .duty_ld_i  (duty_ld),
    .mode_o     (mode_q),
    .cmp_a_o    (cmp_a_q),
    .cmp_b_o    (cmp_b_q),
    .duty_o     (duty_q)
  );

  assign refs[REF_A]    = cmp_a_q;
  assign refs[REF_B]    = cmp_b_q;
  assign refs[REF_DUTY] = duty_q;

  ocmp_match #(.W(W), .N(NUM_REFS)) match_i (
    .cnt_i (tmr_cnt_i),
    .ref_i (refs),
    .hit_o (hits)
  );

  ocmp_pin #(.W(W)) pin_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_q_i    (mode_q),
    .mode_i      (mode_i),
    .mode_wr_i   (mode_wr_i),
    .tmr_prd_i   (tmr_prd_i),
    .hit_i       (hits),
    .next_duty_i (cmp_b_q),
    .duty_ld_o   (duty_ld),
    .pin_o       (pin_o),
    .irq_o       (irq_o),
    .armed_o     (armed_q)
  );
endmodule

// File: rtl/ocmp_unit_chk.sv
module ocmp_unit_chk
  import ocmp_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tmr_prd_i,
  input logic [2:0]   mode_i,
  input logic         mode_wr_i,
  input logic         pin_o,
  input logic         irq_o,
  input oc_mode_e     mode_q,
  input logic [W-1:0] cmp_b_q,
  input logic [W-1:0] duty_q,
  input logic         armed_q
);
  logic off_wr, off_now;
  assign off_wr  = mode_wr_i && ((mode_i == 3'd0) || (mode_i == 3'd7));
  assign off_now = (mode_q == OC_OFF) || (mode_q == OC_OFF7);

  a_r10_off_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_wr |=> !pin_o);
  a_r10_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_now && !mode_wr_i) |=> (!pin_o && !irq_o));
  a_r9_irq_marks_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pin_o != $past(pin_o)));
  a_r9_no_irq_on_mode_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i |=> !irq_o);
  a_r2_set_never_falls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == OC_SET && !mode_wr_i && pin_o) |=> pin_o);
  a_r3_clr_never_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == OC_CLR && !mode_wr_i && !pin_o) |=> !pin_o);
  a_r7_period_loads_duty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == OC_PWM && !mode_wr_i && tmr_prd_i)
      |=> (duty_q == $past(cmp_b_q)) && (pin_o == ($past(cmp_b_q) != '0)));
  a_r5_one_shot_spent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == OC_ONE && !mode_wr_i && !armed_q) |=> !$rose(pin_o));
  a_r11_keep_on_enable_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_wr_i && !off_wr) |=> $stable(pin_o));
endmodule

bind ocmp_unit ocmp_unit_chk #(.W(W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tmr_prd_i (tmr_prd_i),
  .mode_i    (mode_i),
  .mode_wr_i (mode_wr_i),
  .pin_o     (pin_o),
  .irq_o     (irq_o),
  .mode_q    (mode_q),
  .cmp_b_q   (cmp_b_q),
  .duty_q    (duty_q),
  .armed_q   (armed_q)
);

// File: tb/ocmp_unit_tb.sv
module ocmp_unit_tb_top;
  localparam int W      = 16;
  localparam int CLK_NS = 10;
  localparam int PRD    = 20;
  localparam int PLEN   = PRD + 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] tmr = '0;
  logic         tmr_prd;
  logic [2:0]   mode = 3'd0;
  logic         mode_wr = 1'b0;
  logic [W-1:0] cmp_a = '0, cmp_b = '0;
  logic         cmp_a_wr = 1'b0, cmp_b_wr = 1'b0;
  logic         pin, irq;

  int    checks = 0, errors = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;
  assign tmr_prd = (tmr == PRD[W-1:0]);

  ocmp_unit #(.W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tmr_cnt_i(tmr), .tmr_prd_i(tmr_prd),
    .mode_i(mode), .mode_wr_i(mode_wr), .cmp_a_i(cmp_a), .cmp_a_wr_i(cmp_a_wr),
    .cmp_b_i(cmp_b), .cmp_b_wr_i(cmp_b_wr), .pin_o(pin), .irq_o(irq));

  // external timer
  always @(negedge clk) tmr <= (tmr == PRD[W-1:0]) ? '0 : tmr + 1'b1;

  // behavioural reference
  int m_mode, m_a, m_b, m_duty;
  bit m_pin, m_irq, m_armed;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_a = 0; m_b = 0; m_duty = 0;
      m_pin = 0; m_irq = 0; m_armed = 0;
    end else begin
      bit nxt;
      int cnt;
      cnt = int'(tmr);
      nxt = m_pin;
      if (mode_wr) begin
        if (mode == 3'd0 || mode == 3'd7) nxt = 0;
        m_armed = (mode == 3'd4);
        m_mode  = int'(mode);
      end else begin
        case (m_mode)
          1: if (cnt == m_a) nxt = 1;
          2: if (cnt == m_a) nxt = 0;
          3: if (cnt == m_a) nxt = !m_pin;
          4, 5: begin
            if (!m_pin && cnt == m_a && (m_armed || m_mode == 5)) nxt = 1;
            else if (m_pin && cnt == m_b) begin
              nxt = 0;
              if (m_mode == 4) m_armed = 0;
            end
          end
          6: begin
            if (tmr_prd) begin m_duty = m_b; nxt = (m_b != 0); end
            else if (cnt == m_duty) nxt = 0;
          end
          default: nxt = 0;
        endcase
      end
      m_irq = !mode_wr && (nxt != m_pin);
      m_pin = nxt;
      if (cmp_a_wr) m_a = int'(cmp_a);
      if (cmp_b_wr) m_b = int'(cmp_b);
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    check(cur_req, "pin vs model", int'(pin), int'(m_pin));
    check((cur_req == "R9") ? "R9" : {cur_req, "/R9"}, "irq vs model", int'(irq), int'(m_irq));
  end

  task automatic wr_mode(input int m);
    @(negedge clk); mode = m[2:0]; mode_wr = 1'b1;
    @(negedge clk); mode_wr = 1'b0;
  endtask
  task automatic wr_a(input int v);
    @(negedge clk); cmp_a = v[W-1:0]; cmp_a_wr = 1'b1;
    @(negedge clk); cmp_a_wr = 1'b0;
  endtask
  task automatic wr_b(input int v);
    @(negedge clk); cmp_b = v[W-1:0]; cmp_b_wr = 1'b1;
    @(negedge clk); cmp_b_wr = 1'b0;
  endtask
  task automatic observe(input int n, output int rises, output int highs, output int irqs);
    bit prev;
    rises = 0; highs = 0; irqs = 0;
    @(negedge clk); prev = pin;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pin && !prev) rises++;
      if (pin) highs++;
      if (irq) irqs++;
      prev = pin;
    end
  endtask

  initial begin
    int r, h, q;
    repeat (3) @(negedge clk);
    check("R1", "pin in reset", int'(pin), 0);
    check("R1", "irq in reset", int'(irq), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "pin after reset", int'(pin), 0);

    cur_req = "R2";
    wr_a(5); wr_mode(1);
    observe(PLEN * 2, r, h, q);
    check("R2", "pin high after match", int'(pin), 1);
    check("R2", "rises over window", r, 1);

    cur_req = "R3";
    wr_mode(2);
    observe(PLEN * 2, r, h, q);
    check("R3", "pin low after match", int'(pin), 0);

    cur_req = "R4";
    wr_a(7); wr_mode(3);
    observe(PLEN * 3, r, h, q);
    check("R4", "toggle events in 3 periods", q, 3);

    cur_req = "R10";
    wr_mode(0);
    observe(PLEN * 2, r, h, q);
    check("R10", "no activity when off", h + q, 0);

    cur_req = "R5";
    wr_a(3); wr_b(8); wr_mode(4);
    observe(PLEN * 3, r, h, q);
    check("R5", "single pulse count", r, 1);
    check("R5", "single pulse width", h, 5);

    cur_req = "R6";
    wr_mode(5);
    observe(PLEN * 3, r, h, q);
    check("R6", "pulses in 3 periods", r, 3);
    check("R9", "irqs in 3 periods", q, 6);

    cur_req = "R7";
    wr_b(10); wr_mode(6);
    repeat (PLEN * 2) @(negedge clk);
    observe(PLEN, r, h, q);
    check("R7", "high clocks duty 10", h, 11);
    while (tmr != 12) @(negedge clk);
    wr_b(4);
    repeat (PLEN * 2) @(negedge clk);
    observe(PLEN, r, h, q);
    check("R7", "high clocks duty 4", h, 5);

    cur_req = "R8";
    wr_b(0);
    repeat (PLEN * 2) @(negedge clk);
    observe(PLEN, r, h, q);
    check("R8", "high clocks duty 0", h, 0);
    wr_b(30);
    repeat (PLEN * 2) @(negedge clk);
    observe(PLEN, r, h, q);
    check("R8", "high clocks duty above period", h, PLEN);

    cur_req = "R11";
    wr_a(100); wr_mode(3);
    check("R11", "pin kept on enabled mode write", int'(pin), 1);

    cur_req = "R10";
    wr_mode(7);
    check("R10", "off code 7 clears pin", int'(pin), 0);
    observe(PLEN * 2, r, h, q);
    check("R10", "code 7 stays quiet", h + q, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule